// File: doc/BRIEF.md
# UART Receive Buffer with Threshold and Idle Interrupts

This block sits between a UART deserializer and a host. Each completed byte arrives on a valid/ready input stream and is stored in a 16-entry first-in-first-out buffer. The host drains the buffer through a show-ahead valid/ready output stream. While the buffer is not empty, the oldest byte is always visible on `out_data`. A pop happens in any cycle where `out_valid` and `out_ready` are both high.

The input side applies back-pressure by dropping `in_ready` when all 16 entries are taken. A deserializer cannot stall the line, so a byte it offers while `in_ready` is low is discarded, and a sticky overrun flag records the loss. The host clears that flag with a status-read strobe.

Two interrupts tell the host when to drain. The data interrupt follows the fill level against a threshold chosen by a 2-bit select. The idle interrupt fires when a few bytes sit below that threshold and no traffic has occurred for four character times. These character times are counted on an external one-pulse-per-character tick. When flow control is enabled, an active-low request-to-send output is deasserted once the threshold is reached.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the buffer is empty: `fill_level` is 0, `out_valid`, `data_irq`, `timeout_irq`, `overrun` and `rts_n` are all 0, and `in_ready` is 1.
- R2: A byte is taken when `in_valid` and `in_ready` are high at a clock edge. A byte is removed when `out_valid` and `out_ready` are high. Bytes leave in arrival order, and `fill_level` counts the stored bytes.
- R3: The buffer holds 16 bytes. At 16, `in_ready` is 0. A byte offered while `in_ready` is 0 is discarded, leaving contents and level unchanged, and `overrun` is set from the next cycle.
- R4: `overrun` stays set until a cycle with `stat_rd` high, after which it reads 0. If a new drop happens in that same cycle, the flag stays set.
- R5: The threshold is chosen by `trig_sel`: 2'b00 gives 1 byte, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. `data_irq` is 1 exactly when `fill_level` is at or above the threshold.
- R6: `data_irq` falls in the cycle after a pop takes the level below the threshold.
- R7: The buffer may be non-empty, below the threshold, and see no push or pop. Once it has seen 4 `char_tick` pulses in that state, `timeout_irq` is 1. After only 3 pulses it is still 0.
- R8: Any accepted push or pop restarts the idle count and clears `timeout_irq` from the next cycle. An empty buffer never raises it.
- R9: With `flow_en` high, `rts_n` is 1 while `fill_level` is at or above the threshold, and 0 below it. With `flow_en` low, `rts_n` is 0.
- R10: Asserting `out_ready` on an empty buffer keeps `out_data` at the last byte removed and leaves `fill_level` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Space available; low when full |
| out_valid | output | 1 | Buffer holds at least one byte |
| out_ready | input | 1 | Host read strobe; pops when out_valid is high |
| out_data | output | 8 | Oldest byte, or last removed byte when empty |
| trig_sel | input | 2 | Threshold select (1, 4, 8, 14 bytes) |
| char_tick | input | 1 | One pulse per character time |
| flow_en | input | 1 | Enable request-to-send control |
| stat_rd | input | 1 | Host status read; clears overrun |
| fill_level | output | 5 | Number of stored bytes |
| data_irq | output | 1 | Level at or above threshold |
| timeout_irq | output | 1 | Idle data below threshold |
| rts_n | output | 1 | Active-low request-to-send |
| overrun | output | 1 | Sticky flag for a dropped byte |

## Verification
Pointer or count corruption in this block appears at the ports within one cycle. It shows as a `fill_level` that disagrees with the pushes and pops so far, or as a byte on `out_data` out of arrival order on the very next pop. A stuck or miscounting idle timer shows on `timeout_irq` one `char_tick` early or late, or as a failure to clear right after traffic. A wrong threshold entry shows on `data_irq` and `rts_n` together, at exactly the push that crosses the threshold for the selected setting.

// File: rtl/uart_rxbuf_pkg.sv
`timescale 1ns/1ps
package uart_rxbuf_pkg;

  typedef enum logic [1:0] {
    TRIG_SINGLE  = 2'd0,
    TRIG_QUARTER = 2'd1,
    TRIG_HALF    = 2'd2,
    TRIG_HIGH    = 2'd3
  } trig_sel_e;

  // Threshold in bytes for each select code, scaled from the buffer depth.
  function automatic int unsigned trig_bytes(input trig_sel_e sel, input int unsigned depth);
    case (sel)
      TRIG_SINGLE:  return 1;
      TRIG_QUARTER: return depth / 4;
      TRIG_HALF:    return depth / 2;
      default:      return depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rx_fifo_store.sv
`timescale 1ns/1ps
module rx_fifo_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    count;
  logic [WIDTH-1:0] last_q;

  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = wr_en && !full;
  assign pop_ok  = rd_en && !empty;
  assign level   = count;
  assign rd_data = empty ? last_q : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok) begin
        rd_ptr <= rd_ptr + 1'b1;
        last_q <= mem[rd_ptr];
      end
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rx_trig_cmp.sv
`timescale 1ns/1ps
module rx_trig_cmp
  import uart_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic [1:0]    sel,
  input  logic [LW-1:0] level,
  output logic          reached
);

  logic [LW-1:0] thr_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_thr
    assign thr_tab[g] = LW'(trig_bytes(trig_sel_e'(g), DEPTH));
  end

  assign reached = (level >= thr_tab[sel]);

endmodule

// File: rtl/rx_idle_timer.sv
`timescale 1ns/1ps
module rx_idle_timer #(
  parameter int LIMIT = 4,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic expired
);

  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart || !run)   cnt <= '0;
    else if (tick && !expired)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/uart_rx_buffer.sv
`timescale 1ns/1ps
module uart_rx_buffer #(
  parameter int WIDTH     = 8,
  parameter int DEPTH     = 16,
  parameter int IDLE_CHARS = 4,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  input  logic [1:0]       trig_sel,
  input  logic             char_tick,
  input  logic             flow_en,
  input  logic             stat_rd,
  output logic [LW-1:0]    fill_level,
  output logic             data_irq,
  output logic             timeout_irq,
  output logic             rts_n,
  output logic             overrun
);

  logic full, empty, push_ok, pop_ok, at_thr, idle_hit, ovr_q;

  rx_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid),
    .wr_data (in_data),
    .rd_en   (out_ready),
    .rd_data (out_data),
    .full    (full),
    .empty   (empty),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .level   (fill_level)
  );

  rx_trig_cmp #(.DEPTH(DEPTH)) u_thr (
    .sel     (trig_sel),
    .level   (fill_level),
    .reached (at_thr)
  );

  rx_idle_timer #(.LIMIT(IDLE_CHARS)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (push_ok || pop_ok),
    .run     (!empty),
    .tick    (char_tick),
    .expired (idle_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovr_q <= 1'b0;
    else if (in_valid && full)  ovr_q <= 1'b1;
    else if (stat_rd)           ovr_q <= 1'b0;
  end

  assign in_ready    = !full;
  assign out_valid   = !empty;
  assign data_irq    = at_thr;
  assign timeout_irq = idle_hit && !empty && !at_thr;
  assign rts_n       = flow_en && at_thr;
  assign overrun     = ovr_q;

endmodule

// File: rtl/uart_rx_buffer_chk.sv
`timescale 1ns/1ps
module uart_rx_buffer_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic             flow_en,
  input logic             stat_rd,
  input logic [LW-1:0]    fill_level,
  input logic             data_irq,
  input logic             timeout_irq,
  input logic             rts_n,
  input logic             overrun
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LW'(DEPTH)); // R3

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overrun && $stable(fill_level) || $past(out_valid && out_ready)); // R3

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(in_valid && !in_ready)) |=> !overrun); // R4

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !(out_valid && out_ready)) |=> fill_level == $past(fill_level) + 1'b1); // R2

  AST_IRQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    data_irq |-> out_valid); // R5

  AST_TO_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_irq |-> out_valid && !data_irq); // R7

  AST_TO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !timeout_irq); // R8

  AST_RTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !flow_en |-> !rts_n); // R9

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !in_valid) |=> $stable(out_data) && fill_level == '0); // R10

endmodule

bind uart_rx_buffer uart_rx_buffer_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .flow_en     (flow_en),
  .stat_rd     (stat_rd),
  .fill_level  (fill_level),
  .data_irq    (data_irq),
  .timeout_irq (timeout_irq),
  .rts_n       (rts_n),
  .overrun     (overrun)
);

// File: tb/uart_rx_buffer_test.sv
`timescale 1ns/1ps
module uart_rx_buffer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic [1:0] trig_sel = 2'd0;
  logic       char_tick = 1'b0;
  logic       flow_en = 1'b0;
  logic       stat_rd = 1'b0;
  logic [4:0] fill_level;
  logic       data_irq, timeout_irq, rts_n, overrun;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  uart_rx_buffer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .trig_sel(trig_sel),
    .char_tick(char_tick), .flow_en(flow_en), .stat_rd(stat_rd), .fill_level(fill_level),
    .data_irq(data_irq), .timeout_irq(timeout_irq), .rts_n(rts_n), .overrun(overrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int thr_of(input int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic push(input logic [7:0] d);
    @(negedge clk); in_valid = 1'b1; in_data = d;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string tag);
    @(negedge clk);
    check(out_valid && out_data == exp, tag, out_data, exp);
    out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  task automatic ctick();
    @(negedge clk); char_tick = 1'b1;
    @(negedge clk); char_tick = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk); out_ready = 1'b1;
    while (out_valid) @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(fill_level == 0 && !out_valid && in_ready, "R1 level/valid", fill_level, 0);
    check(!data_irq && !timeout_irq && !overrun && !rts_n, "R1 flags",
          {data_irq, timeout_irq, overrun, rts_n}, 0);
  endtask

  task automatic t_order();
    trig_sel = 2'd3;
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i * 3));
    @(negedge clk);
    check(fill_level == 5, "R2 level after 5", fill_level, 5);
    for (int i = 0; i < 5; i++) pop_expect(8'hA0 + 8'(i * 3), "R2 order");
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
    check(out_data == 8'hAC && fill_level == 0, "R10 empty read", out_data, 8'hAC);
  endtask

  task automatic t_thresholds();
    flow_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      int t;
      t = thr_of(s);
      trig_sel = 2'(s);
      for (int i = 0; i < t - 1; i++) push(8'(i));
      @(negedge clk);
      check(!data_irq, "R5 below threshold", data_irq, 0);
      check(!rts_n, "R9 rts asserted below", rts_n, 0);
      push(8'h55);
      @(negedge clk);
      check(data_irq, "R5 at threshold", data_irq, 1);
      check(rts_n, "R9 rts deasserted at threshold", rts_n, 1);
      @(negedge clk); out_ready = 1'b1;
      @(negedge clk); out_ready = 1'b0;
      check(!data_irq, "R6 irq clears after pop", data_irq, 0);
      check(!rts_n, "R9 rts reasserted", rts_n, 0);
      drain();
    end
    flow_en = 1'b0;
  endtask

  task automatic t_overrun();
    trig_sel = 2'd3;
    for (int i = 0; i < 16; i++) push(8'h40 + 8'(i));
    @(negedge clk);
    check(fill_level == 16 && !in_ready, "R3 full", fill_level, 16);
    check(!rts_n, "R9 rts low when disabled", rts_n, 0);
    check(!overrun, "R3 no overrun yet", overrun, 0);
    push(8'hEE);
    @(negedge clk);
    check(overrun && fill_level == 16, "R3 drop sets overrun", overrun, 1);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check(!overrun, "R4 status read clears", overrun, 0);
    @(negedge clk); stat_rd = 1'b1; in_valid = 1'b1; in_data = 8'hEF;
    @(negedge clk); stat_rd = 1'b0; in_valid = 1'b0;
    check(overrun, "R4 new drop wins over clear", overrun, 1);
    for (int i = 0; i < 16; i++) pop_expect(8'h40 + 8'(i), "R3 contents kept");
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_timeout();
    trig_sel = 2'd2;
    for (int i = 0; i < 3; i++) ctick();
    @(negedge clk);
    check(!timeout_irq, "R8 empty never times out", timeout_irq, 0);
    push(8'h11); push(8'h22);
    for (int i = 0; i < 3; i++) ctick();
    @(negedge clk);
    check(!timeout_irq, "R7 three ticks", timeout_irq, 0);
    ctick();
    @(negedge clk);
    check(timeout_irq, "R7 four ticks", timeout_irq, 1);
    pop_expect(8'h11, "R2 pop during timeout");
    @(negedge clk);
    check(!timeout_irq && fill_level == 1, "R8 pop restarts", timeout_irq, 0);
    for (int i = 0; i < 4; i++) ctick();
    @(negedge clk);
    check(timeout_irq, "R7 fires again", timeout_irq, 1);
    push(8'h33);
    @(negedge clk);
    check(!timeout_irq, "R8 push restarts", timeout_irq, 0);
    drain();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_thresholds();
    t_overrun();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule